// File: doc/BRIEF.md
# Synchronous Burst Memory Port Controller

This block sits behind a synchronous, burst-capable memory port and owns a small byte-lane memory array. On every rising clock edge it reads the chip-select inputs, the two address strobes, the advance input and the write controls. From these it sorts the cycle into one of four kinds: a deselect, the start of a new burst at an external address, a continued burst at the next internal address, or a held (suspended) burst at the same address. It then performs a read or a byte-masked write on the array.

The two strobes are not equal. The host strobe wins over the controller strobe, always starts a read, and is masked by the first chip select. The controller strobe can start reads or writes. Read data leaves the block either in the interval right after the access edge (flow-through) or one edge later from an output register (pipelined), chosen by a mode input. An output-enable input can only remove the drive; it never creates it. The read-data pins are modelled as a data bus plus a drive qualifier, which the pad ring turns into a tristate.

A port that tie the host strobe high and pulse the controller strobe for every access gets plain single-cycle synchronous operation. Holding the advance input low then turns each access into a four-beat burst.

Top module: `burst_mem_port`

## Requirements
- R1: A cycle in which either strobe is accepted opens an access only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. Any other combination makes it a deselect: no array write, no drive for that cycle, and no drive for the continue or hold cycles that follow.
- R2: In cycles where neither strobe is low, `en_b` and `en_c_n` are ignored: an open burst continues or holds whatever their values.
- R3: While `en_a_n`=1 the host strobe is blocked. With `strobe_ctl_n`=1 such a cycle is a continue cycle (`advance_n`=0) or a hold cycle (`advance_n`=1), not a new burst.
- R4: A burst started by the host strobe (`strobe_host_n`=0 with `en_a_n`=0) is a read, whatever the write inputs say, and it takes priority over a simultaneous controller strobe.
- R5: Lane i is bits [8i+7:8i] of `wdata`/`rdata`. With `wr_all_n`=0 all lanes are written. Otherwise, with `wr_lane_en_n`=0, exactly the lanes whose `lane_sel_n` bit is 0 are written. Every other combination, including no lane selected, is a read.
- R6: Write data, address and lane mask are taken on the same edge. A write cycle never drives `rdata_drive`: in flow-through mode the interval after a write edge is undriven.
- R7: With `pipe_mode`=0, a read's data for the address used on edge n is driven, with all lanes, in the interval from edge n to edge n+1.
- R8: With `pipe_mode`=1, the same read data is driven in the interval from edge n+1 to edge n+2. A deselect therefore releases the bus only after that one pending beat.
- R9: `out_en_n`=1 forces `rdata_drive` low at once, without a clock edge. A read made while it is high is a dummy read that still moves the burst address.
- R10: A continue cycle adds one to the two low address bits, wrapping modulo 4 and keeping the upper bits. A hold cycle reuses the current address. Both choose read or write from the write inputs of that cycle.
- R11: After reset the port is deselected and `rdata_drive` is 0. Continue and hold cycles after a deselect neither write nor drive until a new burst opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_a_n | input | 1 | First chip select, active low; also masks the host strobe |
| en_b | input | 1 | Second chip select, active high |
| en_c_n | input | 1 | Third chip select, active low |
| strobe_host_n | input | 1 | Host address strobe, active low, read only |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| wr_lane_en_n | input | 1 | Enable per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| addr | input | AW | External word address |
| wdata | input | 8*LANES | Write data |
| pipe_mode | input | 1 | 1 = registered read data, 0 = flow-through |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 8*LANES | Read data, zero when not driven |
| rdata_drive | output | 1 | High while the read-data bus is driven |

## Verification
The bench first fills the array with full-word writes. It then runs partial-lane writes (alternate lanes, no lane, all lanes via both controls) and reads them back in flow-through mode, which separates the lane-mask decode from the data path. Four-beat bursts are started at a non-aligned address, mixed with hold cycles, and run in both read modes, which exposes the wrap rule and the one-edge offset between the modes. Host-strobe starts that carry active write controls, blocked host strobes, chip selects changing during continue cycles, deselected strobes and stray advance pulses after a deselect each differ from the normal decode in only one input. A dummy read with the output enable high shows that the address still advances while the bus stays undriven.

// File: rtl/bmp_pkg.sv
// Shared types of the burst memory port.
// Assumes: nothing beyond IEEE 1800-2017.
package bmp_pkg;
    // Kind of bus cycle decoded from strobes and advance
    typedef enum logic [1:0] {
        CYC_NEW  = 2'd0,  // a strobe was accepted: new external address
        CYC_NEXT = 2'd1,  // continue burst at next internal address
        CYC_HOLD = 2'd2   // suspend: reuse current address
    } cyc_kind_t;
endpackage

// File: rtl/bmp_cycle_decode.sv
// Cycle decoder and burst address state.
// Decides per clock whether the port starts, continues, holds or deselects
// an access, computes the word address used on this edge and the lane
// write mask. Assumes AW >= 3 (two low bits form the burst counter).
module bmp_cycle_decode
    import bmp_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             strobe_host_n,
    input  logic             strobe_ctl_n,
    input  logic             advance_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic [AW-1:0]    addr,
    output logic [AW-1:0]    acc_addr,
    output logic [AW-1:0]    held_addr,
    output logic [LANES-1:0] we_mask,
    output logic             rd_go,
    output logic             wr_go
);
    localparam int CNT_W = 2;

    logic             host_ok;
    logic             any_strobe;
    logic             sel_ok;
    logic             wants_wr;
    logic             go;
    logic             active_q;
    logic [AW-1:0]    burst_q;
    logic [LANES-1:0] lane_mask;
    cyc_kind_t        kind;

    // Classify the cycle and form the lane mask
    always_comb begin
        host_ok    = !strobe_host_n && !en_a_n;
        any_strobe = host_ok || !strobe_ctl_n;
        sel_ok     = !en_a_n && en_b && !en_c_n;
        if (any_strobe)      kind = CYC_NEW;
        else if (!advance_n) kind = CYC_NEXT;
        else                 kind = CYC_HOLD;
        if (!wr_all_n)          lane_mask = '1;
        else if (!wr_lane_en_n) lane_mask = ~lane_sel_n;
        else                    lane_mask = '0;
    end

    // Address used on this edge and the access decision
    always_comb begin
        case (kind)
            CYC_NEW:  acc_addr = addr;
            CYC_NEXT: acc_addr = {burst_q[AW-1:CNT_W], burst_q[CNT_W-1:0] + 2'd1};
            default:  acc_addr = burst_q;
        endcase
        wants_wr = (kind == CYC_NEW && host_ok) ? 1'b0 : (|lane_mask);
        go       = (kind == CYC_NEW) ? sel_ok : active_q;
        rd_go    = go && !wants_wr;
        wr_go    = go && wants_wr;
        we_mask  = wr_go ? lane_mask : '0;
    end

    // Burst state: open/closed flag and last used address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            burst_q  <= '0;
        end else begin
            if (kind == CYC_NEW) active_q <= sel_ok;
            burst_q <= acc_addr;
        end
    end

    assign held_addr = burst_q;

    assert_blocked_host_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_host_n && en_a_n && strobe_ctl_n) |=> (active_q == $past(active_q)));

    assert_bad_select_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n && (!en_b || en_c_n)) |=> !active_q);

    assert_burst_wraps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_host_n && strobe_ctl_n && !advance_n)
        |=> (burst_q[1:0] == $past(burst_q[1:0]) + 2'd1));

    assert_hold_keeps_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_host_n && strobe_ctl_n && advance_n) |=> $stable(burst_q));
endmodule

// File: rtl/bmp_lane_store.sv
// Byte-lane memory array: one 8-bit array per lane, written per lane mask
// on the rising edge, read asynchronously at a separate address.
// Assumes DEPTH stays small enough for flops.
module bmp_lane_store #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic [LANES-1:0]   we_mask,
    input  logic [AW-1:0]      waddr,
    input  logic [8*LANES-1:0] wdata,
    input  logic [AW-1:0]      raddr,
    output logic [8*LANES-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [DEPTH];

        // Write this lane when its mask bit is set
        always_ff @(posedge clk) begin
            if (we_mask[g]) cells[waddr] <= wdata[8*g +: 8];
        end

        assign rdata[8*g +: 8] = cells[raddr];
    end
endmodule

// File: rtl/bmp_read_stage.sv
// Read output stage: tracks which intervals carry read data and selects
// flow-through or registered data; output enable only removes drive.
// Assumes arr_data reflects the address of the last accepted access.
module bmp_read_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_go,
    input  logic [W-1:0] arr_data,
    input  logic         pipe_mode,
    input  logic         out_en_n,
    output logic [W-1:0] rdata,
    output logic         rdata_drive
);
    logic         flow_v;
    logic         pipe_v;
    logic [W-1:0] pipe_d;

    // Track the read beat and its one-edge-delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flow_v <= 1'b0;
            pipe_v <= 1'b0;
            pipe_d <= '0;
        end else begin
            flow_v <= rd_go;
            pipe_v <= flow_v;
            pipe_d <= arr_data;
        end
    end

    // Select the beat for the current mode and gate it with output enable
    always_comb begin
        rdata_drive = (pipe_mode ? pipe_v : flow_v) && !out_en_n;
        rdata       = rdata_drive ? (pipe_mode ? pipe_d : arr_data) : '0;
    end

    assert_read_reaches_register_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flow_v |=> pipe_v);
endmodule

// File: rtl/burst_mem_port.sv
// Top of the synchronous burst memory port: decoder, lane array and read
// stage. Assumes mode and output enable are driven by the host side.
module burst_mem_port #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_a_n,
    input  logic               en_b,
    input  logic               en_c_n,
    input  logic               strobe_host_n,
    input  logic               strobe_ctl_n,
    input  logic               advance_n,
    input  logic               wr_all_n,
    input  logic               wr_lane_en_n,
    input  logic [LANES-1:0]   lane_sel_n,
    input  logic [AW-1:0]      addr,
    input  logic [8*LANES-1:0] wdata,
    input  logic               pipe_mode,
    input  logic               out_en_n,
    output logic [8*LANES-1:0] rdata,
    output logic               rdata_drive
);
    localparam int W = 8 * LANES;

    logic [AW-1:0]    acc_addr;
    logic [AW-1:0]    held_addr;
    logic [LANES-1:0] we_mask;
    logic             rd_go;
    logic             wr_go;
    logic [W-1:0]     arr_data;

    bmp_cycle_decode #(.AW(AW), .LANES(LANES)) u_dec (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .strobe_host_n(strobe_host_n), .strobe_ctl_n(strobe_ctl_n),
        .advance_n(advance_n), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
        .lane_sel_n(lane_sel_n), .addr(addr), .acc_addr(acc_addr),
        .held_addr(held_addr), .we_mask(we_mask), .rd_go(rd_go), .wr_go(wr_go)
    );

    bmp_lane_store #(.AW(AW), .LANES(LANES)) u_store (
        .clk(clk), .we_mask(we_mask), .waddr(acc_addr), .wdata(wdata),
        .raddr(held_addr), .rdata(arr_data)
    );

    bmp_read_stage #(.W(W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .arr_data(arr_data),
        .pipe_mode(pipe_mode), .out_en_n(out_en_n), .rdata(rdata),
        .rdata_drive(rdata_drive)
    );

    assert_host_start_never_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_host_n && !en_a_n) |-> (we_mask == '0));

    assert_write_leaves_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (pipe_mode || !rdata_drive));
endmodule

// File: tb/burst_mem_port_tb_top.sv
// Bench: behavioural reference model compared with the ports every clock.
module burst_mem_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic        strobe_host_n = 1'b1, strobe_ctl_n = 1'b1, advance_n = 1'b1;
    logic        wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        pipe_mode = 1'b1, out_en_n = 1'b0;
    logic [31:0] rdata;
    logic        rdata_drive;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R11";

    // reference model state
    logic [7:0]  mm [64][4];
    bit          m_act = 0, m_fv = 0, m_pv = 0;
    int          m_baddr = 0, m_faddr = 0;
    logic [31:0] m_pd = '0;

    burst_mem_port dut_i (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .strobe_host_n(strobe_host_n), .strobe_ctl_n(strobe_ctl_n),
        .advance_n(advance_n), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
        .lane_sel_n(lane_sel_n), .addr(addr), .wdata(wdata), .pipe_mode(pipe_mode),
        .out_en_n(out_en_n), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] word_at(int a);
        return {mm[a][3], mm[a][2], mm[a][1], mm[a][0]};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the requirement rules
    task automatic model_edge();
        bit host, strobe, sel, wr, go;
        logic [3:0] mask;
        int cur;
        logic [31:0] next_pd;
        next_pd = word_at(m_faddr);
        host   = (strobe_host_n == 0) && (en_a_n == 0);
        strobe = host || (strobe_ctl_n == 0);
        sel    = (en_a_n == 0) && (en_b == 1) && (en_c_n == 0);
        if (wr_all_n == 0) mask = 4'hF;
        else if (wr_lane_en_n == 0) mask = ~lane_sel_n;
        else mask = 4'h0;
        if (strobe) cur = int'(addr);
        else if (advance_n == 0) cur = (m_baddr & ~3) | ((m_baddr + 1) & 3);
        else cur = m_baddr;
        go = strobe ? sel : m_act;
        wr = go && !(strobe && host) && (mask != 0);
        if (wr)
            for (int l = 0; l < 4; l++) if (mask[l]) mm[cur][l] = wdata[8*l +: 8];
        if (strobe) m_act = sel;
        m_pv = m_fv;
        m_pd = next_pd;
        m_fv = go && !wr;
        m_faddr = cur;
        m_baddr = cur;
    endtask

    task automatic compare();
        bit drv;
        logic [31:0] d;
        drv = !out_en_n && (pipe_mode ? m_pv : m_fv);
        d = drv ? (pipe_mode ? m_pd : word_at(m_faddr)) : 32'h0;
        chk(rdata_drive == drv, {cur_req, " drive"}, {31'h0, rdata_drive}, {31'h0, drv});
        if (drv) chk(rdata == d, {cur_req, " data"}, rdata, d);
    endtask

    task automatic cyc(bit hn, bit cn, bit an, bit e1, bit e2, bit e3, bit ga, bit be,
                       logic [3:0] bs, logic [5:0] a, logic [31:0] wd, bit oe);
        @(negedge clk);
        strobe_host_n = hn; strobe_ctl_n = cn; advance_n = an;
        en_a_n = e1; en_b = e2; en_c_n = e3; wr_all_n = ga; wr_lane_en_n = be;
        lane_sel_n = bs; addr = a; wdata = wd; out_en_n = oe;
        @(posedge clk);
        model_edge();
        #1 compare();
    endtask

    task automatic wr_new(logic [5:0] a, bit ga, bit be, logic [3:0] bs, logic [31:0] wd);
        cyc(1, 0, 1, 0, 1, 0, ga, be, bs, a, wd, 0);
    endtask
    task automatic rd_new(logic [5:0] a);
        cyc(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, a, 32'h0, 0);
    endtask
    task automatic rd_cont(bit an);
        cyc(1, 1, an, 0, 1, 0, 1, 1, 4'hF, 6'h3F, 32'h0, 0);
    endtask
    task automatic desel();
        cyc(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 6'h00, 32'h0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 64; a++) for (int l = 0; l < 4; l++) mm[a][l] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 chk(rdata_drive == 0, "R11 reset drive", {31'h0, rdata_drive}, 32'h0);

        // R6: full writes in flow-through mode
        pipe_mode = 0; cur_req = "R6";
        for (int a = 0; a < 8; a++) wr_new(6'(a), 0, 1, 4'hF, 32'hA0B0C0D0 + a * 32'h01010101);
        // R5: lane masks
        cur_req = "R5";
        wr_new(6'd1, 1, 0, 4'b1010, 32'h11223344);
        wr_new(6'd2, 1, 0, 4'b1111, 32'h55667788);
        wr_new(6'd3, 1, 1, 4'b0000, 32'h99AABBCC);
        wr_new(6'd4, 0, 0, 4'b1111, 32'hDEADBEEF);
        wr_new(6'd5, 1, 0, 4'b0111, 32'h12345678);
        // R7: flow-through read back
        cur_req = "R7";
        for (int a = 0; a < 6; a++) rd_new(6'(a));
        desel();

        // R8: pipelined reads and deselect release
        pipe_mode = 1; cur_req = "R8";
        for (int a = 1; a < 5; a++) rd_new(6'(a));
        desel(); desel();

        // R4: host strobe starts carry write controls but read
        cur_req = "R4";
        cyc(0, 1, 1, 0, 1, 0, 0, 0, 4'h0, 6'd5, 32'hFFFFFFFF, 0);
        cyc(0, 0, 1, 0, 1, 0, 1, 0, 4'h0, 6'd6, 32'hEEEEEEEE, 0);
        desel();
        rd_new(6'd5); rd_new(6'd6); desel(); desel();

        // R10: burst write from non-aligned start, then burst reads with hold
        pipe_mode = 0; cur_req = "R10";
        wr_new(6'd6, 0, 1, 4'hF, 32'h60606060);
        for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 6'h00, 32'h70000000 + k, 0);
        desel();
        rd_new(6'd6); rd_cont(0); rd_cont(1); rd_cont(0); rd_cont(0); rd_cont(0);
        desel();
        pipe_mode = 1;
        rd_new(6'd5); rd_cont(0); rd_cont(0); rd_cont(1); rd_cont(0);
        desel(); desel();

        // R3: blocked host strobe continues or holds the open burst
        pipe_mode = 0; cur_req = "R3";
        rd_new(6'd1);
        cyc(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 6'd20, 32'h0, 0);
        cyc(0, 1, 1, 1, 1, 0, 1, 1, 4'hF, 6'd20, 32'h0, 0);
        desel();

        // R2: selects ignored without a strobe
        cur_req = "R2";
        rd_new(6'd0);
        cyc(1, 1, 0, 0, 0, 1, 1, 1, 4'hF, 6'd0, 32'h0, 0);
        cyc(1, 1, 1, 0, 0, 0, 1, 1, 4'hF, 6'd0, 32'h0, 0);
        desel();

        // R1: strobes with a bad select are deselects
        cur_req = "R1";
        rd_new(6'd2);
        cyc(1, 0, 1, 0, 0, 0, 1, 1, 4'hF, 6'd3, 32'h0, 0);
        cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd3, 32'h0, 0);
        cyc(1, 0, 1, 0, 1, 1, 0, 1, 4'hF, 6'd3, 32'hBADBAD00, 0);
        cyc(0, 1, 1, 0, 0, 0, 1, 1, 4'hF, 6'd3, 32'h0, 0);
        rd_new(6'd3); desel();

        // R9: dummy reads with output enable high still advance
        pipe_mode = 1; cur_req = "R9";
        cyc(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 6'd4, 32'h0, 1);
        cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0, 1);
        cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0, 0);
        cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0, 0);
        desel(); desel();
        pipe_mode = 0;
        cyc(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 6'd1, 32'h0, 1);
        cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0, 0);
        desel();

        // R11: continue/hold after a deselect neither write nor drive
        cur_req = "R11";
        cyc(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 6'd2, 32'h0, 0);
        cyc(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 6'd0, 32'hCAFECAFE, 0);
        cyc(1, 1, 1, 0, 1, 0, 0, 1, 4'hF, 6'd0, 32'hCAFECAFE, 0);
        cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0, 0);
        for (int a = 0; a < 8; a++) rd_new(6'(a));
        desel();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule